// File: doc/BRIEF.md
# Serial Audio Receiver with Clock-Loss Mute

This block receives stereo audio from an external serial master. The master drives a bit clock, a frame clock that marks which channel is on the line, and a data line. The block does not generate any of these clocks. All three lines are oversampled by a free-running system clock through two-flop synchronisers. Samples are recovered as 24-bit words, most significant bit first. A static format pin selects left-justified or I2S framing. Each completed stereo pair is presented on parallel outputs with a one-cycle valid strobe.

A bit-clock activity monitor counts system cycles since the last synchronised bit-clock edge. When that count reaches a parameterised timeout, the outputs are forced to zero. The monitor releases the mute only after one whole stereo frame has arrived on a running clock. A separate mute pin also zeroes the outputs at any time. Frame length is not fixed: longer half-frames are truncated to 24 bits, and shorter ones are padded with zeros at the LSB end.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, valid_o is 0, left_o and right_o are 0, and auto_mute_o is 1.
- R2: With fmt_i = 0 (left-justified), frame clock high marks the left channel. The MSB is the bit sampled on the first bit-clock rising edge after a frame-clock change, and the following bits come in descending order.
- R3: With fmt_i = 1 (I2S), frame clock low marks the left channel. The bit on the first rising edge after a frame-clock change is discarded, and the MSB is taken on the second rising edge.
- R4: Bits after the 24th data bit of a half-frame do not change the recovered word.
- R5: A half-frame with fewer than 24 data bits yields a word whose unreceived low-order bits are zero.
- R6: valid_o is a single-cycle pulse. It is raised when the frame-clock change that opens a left half is seen, closing a right half that followed a complete left half. The half-frame already in progress when reception starts is never emitted.
- R7: While mute_i is 1, left_o and right_o are 0 in the same cycle. valid_o is not affected.
- R8: auto_mute_o rises once TIMEOUT consecutive system cycles pass without a synchronised bit-clock edge. While it is 1, left_o and right_o are 0.
- R9: After a mute, auto_mute_o falls only after two things happen in order: a frame-clock change opens a left half, and then that stereo pair completes. A pair that completes on the arming change itself stays zeroed.
- R10: Serial inputs pass through two synchroniser flops. A bit-clock rising edge at the pins affects the outputs after the third system clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_clk_i | input | 1 | Serial bit clock from the external master |
| frame_clk_i | input | 1 | Left/right framing clock from the external master |
| ser_data_i | input | 1 | Serial audio data, MSB first |
| fmt_i | input | 1 | Framing select: 0 left-justified, 1 I2S (static) |
| mute_i | input | 1 | Forces both sample outputs to zero while high |
| left_o | output | SAMPLE_W | Left sample of the last completed pair |
| right_o | output | SAMPLE_W | Right sample of the last completed pair |
| valid_o | output | 1 | One-cycle strobe marking a new stereo pair |
| auto_mute_o | output | 1 | High while the clock-loss mute is in force |

## Verification
Two functions can fall on the same bit-clock edge. The frame-clock change that completes a pair also opens the next left half, so the change that re-arms the clock-loss monitor can complete a pair at the same moment. The bench provokes this by stopping the bit clock after a left half and then resuming with the matching right half. The resulting pair must strobe with zeros while the monitor arms, and only the following pair may be heard. The bench also holds mute_i across the strobe of a pair and expects zero data with the strobe intact. A behavioural model compares every output on every cycle, and a list of captured pairs is compared against the words sent.

// File: rtl/sarx_pkg.sv
`timescale 1ns/1ps
package sarx_pkg;

  typedef enum logic {
    FMT_LEFT_JUST = 1'b0,
    FMT_I2S       = 1'b1
  } fmt_e;

  typedef enum logic [1:0] {
    MON_MUTED = 2'd0,
    MON_ARMED = 2'd1,
    MON_LIVE  = 2'd2
  } mon_state_e;

  typedef struct packed {
    logic rise;    // synced bit clock rising edge
    logic toggle;  // any synced bit clock edge
    logic lr;      // synced frame clock
    logic dat;     // synced serial data
  } ser_evt_t;

  function automatic logic chan_is_left(input logic lr, input logic fmt);
    return (fmt == FMT_I2S) ? ~lr : lr;
  endfunction

endpackage

// File: rtl/sarx_sync.sv
`timescale 1ns/1ps
module sarx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/sarx_deser.sv
`timescale 1ns/1ps
module sarx_deser
  import sarx_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ser_evt_t     evt_i,
  input  logic         fmt_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o,
  output logic         pair_evt_o,   // combinational: pair completes on this rise
  output logic         start_evt_o   // combinational: left half opens on this rise
);

  localparam int unsigned CW = $clog2(W + 2);
  localparam int unsigned IW = $clog2(W);
  localparam logic [CW-1:0] CNT_MAX = CW'(W + 1);

  logic          have_prev_q, lr_prev_q, in_word_q, left_ok_q, valid_q;
  logic [CW-1:0] cnt_q, slot, cnt_nxt;
  logic [W-1:0]  word_q, word_base, word_nxt, lhold_q, left_q, right_q;
  logic          trans, done_word, prev_left, cur_left;
  logic [IW-1:0] bit_pos;
  int            slot_i;

  assign trans       = evt_i.rise & have_prev_q & (evt_i.lr != lr_prev_q);
  assign prev_left   = chan_is_left(lr_prev_q, fmt_i);
  assign cur_left    = chan_is_left(evt_i.lr, fmt_i);
  assign done_word   = trans & in_word_q;
  assign pair_evt_o  = done_word & ~prev_left & left_ok_q;
  assign start_evt_o = trans & cur_left;

  assign slot      = trans ? '0 : cnt_q;
  assign word_base = trans ? '0 : word_q;
  assign cnt_nxt   = (slot == CNT_MAX) ? CNT_MAX : slot + CW'(1);

  // place the incoming bit; I2S skips the slot on the frame change
  always_comb begin
    word_nxt = word_base;
    slot_i   = int'(slot);
    bit_pos  = '0;
    if (fmt_i == FMT_I2S) begin
      if (slot_i >= 1 && slot_i <= int'(W)) begin
        bit_pos           = IW'(int'(W) - slot_i);
        word_nxt[bit_pos] = evt_i.dat;
      end
    end else begin
      if (slot_i < int'(W)) begin
        bit_pos           = IW'(int'(W) - 1 - slot_i);
        word_nxt[bit_pos] = evt_i.dat;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      lr_prev_q   <= 1'b0;
      in_word_q   <= 1'b0;
      left_ok_q   <= 1'b0;
      cnt_q       <= '0;
      word_q      <= '0;
      lhold_q     <= '0;
    end else if (evt_i.rise) begin
      have_prev_q <= 1'b1;
      lr_prev_q   <= evt_i.lr;
      cnt_q       <= cnt_nxt;
      word_q      <= word_nxt;
      if (trans) in_word_q <= 1'b1;
      if (done_word) begin
        if (prev_left) begin
          lhold_q   <= word_q;
          left_ok_q <= 1'b1;
        end else begin
          left_ok_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      valid_q <= pair_evt_o;
      if (pair_evt_o) begin
        left_q  <= lhold_q;
        right_q <= word_q;
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

  a_r6_valid_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  a_r2_frame_change_restarts_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.rise && have_prev_q && (evt_i.lr != lr_prev_q)) |=> (cnt_q == CW'(1)));

endmodule

// File: rtl/sarx_clk_mon.sv
`timescale 1ns/1ps
module sarx_clk_mon
  import sarx_pkg::*;
#(
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  input  logic start_i,
  input  logic pair_i,
  output logic auto_mute_o
);

  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT);

  logic [CW-1:0] idle_q;
  mon_state_e    state_q, state_d;
  logic          tmo;

  assign tmo = ~toggle_i & (idle_q == LIM - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
    end else if (toggle_i) begin
      idle_q <= '0;
    end else if (idle_q != LIM) begin
      idle_q <= idle_q + CW'(1);
    end
  end

  // arming and release; a timeout wins over both
  always_comb begin
    state_d = state_q;
    if (tmo) begin
      state_d = MON_MUTED;
    end else begin
      case (state_q)
        MON_MUTED: if (start_i) state_d = MON_ARMED;
        MON_ARMED: if (pair_i)  state_d = MON_LIVE;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= MON_MUTED;
    else         state_q <= state_d;
  end

  assign auto_mute_o = (state_q != MON_LIVE);

  a_r8_idle_limit_is_muted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q == LIM) |-> (state_q == MON_MUTED));

  a_r9_release_only_from_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MON_LIVE && $past(state_q) != MON_LIVE) |-> ($past(state_q) == MON_ARMED));

endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned TIMEOUT     = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_clk_i,
  input  logic                frame_clk_i,
  input  logic                ser_data_i,
  input  logic                fmt_i,
  input  logic                mute_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                auto_mute_o
);

  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0]     sync_q;
  logic                sclk_q;
  ser_evt_t            evt;
  logic [SAMPLE_W-1:0] left_raw, right_raw;
  logic                pair_evt, start_evt, auto_mute;

  sarx_sync #(
    .W      (NSIG),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ser_data_i, frame_clk_i, bit_clk_i}),
    .q_o    (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sync_q[0];
  end

  assign evt.rise   = sync_q[0] & ~sclk_q;
  assign evt.toggle = sync_q[0] ^ sclk_q;
  assign evt.lr     = sync_q[1];
  assign evt.dat    = sync_q[2];

  sarx_deser #(
    .W (SAMPLE_W)
  ) u_deser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .fmt_i       (fmt_i),
    .left_o      (left_raw),
    .right_o     (right_raw),
    .valid_o     (valid_o),
    .pair_evt_o  (pair_evt),
    .start_evt_o (start_evt)
  );

  sarx_clk_mon #(
    .TIMEOUT (TIMEOUT)
  ) u_clk_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .toggle_i    (evt.toggle),
    .start_i     (start_evt),
    .pair_i      (pair_evt),
    .auto_mute_o (auto_mute)
  );

  assign auto_mute_o = auto_mute;
  assign left_o      = (mute_i | auto_mute) ? '0 : left_raw;
  assign right_o     = (mute_i | auto_mute) ? '0 : right_raw;

  a_r10_valid_follows_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(evt.rise));

endmodule

// File: tb/serial_audio_rx_bench.sv
`timescale 1ns/1ps
module serial_audio_rx_bench;

  localparam int TMO = 64;
  localparam int HB  = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_clk_i = 1'b0, frame_clk_i = 1'b0, ser_data_i = 1'b0;
  logic        fmt_i = 1'b0, mute_i = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o, auto_mute_o;

  int checks = 0, errors = 0;
  bit chk_en = 1'b0;

  always #2.5 clk_i = ~clk_i;

  serial_audio_rx #(.SAMPLE_W(24), .TIMEOUT(TMO), .SYNC_STAGES(2)) u_serial_audio_rx (
    .clk_i, .rst_ni, .bit_clk_i, .frame_clk_i, .ser_data_i, .fmt_i, .mute_i,
    .left_o, .right_o, .valid_o, .auto_mute_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [2:0]  h1, h2, h3;
  bit          m_have, m_lrp, m_inw, m_lok;
  int          m_cnt, m_idle, m_st;
  logic [23:0] m_word, m_lh, e_l, e_r;
  bit          e_v;

  function automatic bit left_of(input bit lr);
    return fmt_i ? !lr : lr;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      h1 = '0; h2 = '0; h3 = '0;
      m_have = 0; m_lrp = 0; m_inw = 0; m_lok = 0;
      m_cnt = 0; m_idle = 0; m_st = 0;
      m_word = '0; m_lh = '0; e_l = '0; e_r = '0; e_v = 0;
    end else begin
      bit rise, tog, lr, d, tr, pair, start, tmo;
      int pos;
      rise = h2[0] && !h3[0];
      tog  = h2[0] != h3[0];
      lr   = h2[1];
      d    = h2[2];
      pair = 0; start = 0; e_v = 0;
      if (rise) begin
        tr = m_have && (lr != m_lrp);
        if (tr) begin
          start = left_of(lr);
          if (m_inw) begin
            if (left_of(m_lrp)) begin m_lh = m_word; m_lok = 1; end
            else begin
              if (m_lok) begin pair = 1; e_l = m_lh; e_r = m_word; end
              m_lok = 0;
            end
          end
          m_inw = 1; m_cnt = 0; m_word = '0;
        end
        pos = fmt_i ? m_cnt - 1 : m_cnt;
        if (pos >= 0 && pos < 24) m_word[23-pos] = d;
        m_cnt++;
        m_have = 1; m_lrp = lr;
        e_v = pair;
      end
      tmo = !tog && (m_idle == TMO - 1);
      if (tmo) m_st = 0;
      else if (m_st == 0 && start) m_st = 1;
      else if (m_st == 1 && pair) m_st = 2;
      if (tog) m_idle = 0; else if (m_idle < TMO) m_idle++;
      h3 = h2; h2 = h1; h1 = {ser_data_i, frame_clk_i, bit_clk_i};
    end
  end

  logic [23:0] cap_l[$], cap_r[$], exp_l[$], exp_r[$];
  string       exp_tag[$];

  always @(posedge clk_i) begin
    #1;
    if (rst_ni && chk_en) begin
      logic [23:0] xl, xr;
      bit mm;
      mm = (m_st != 2);
      xl = (mute_i || mm) ? '0 : e_l;
      xr = (mute_i || mm) ? '0 : e_r;
      check(valid_o == e_v, "R6 R10", "valid_o", 32'(valid_o), 32'(e_v));
      check(auto_mute_o == mm, "R8 R9", "auto_mute_o", 32'(auto_mute_o), 32'(mm));
      check(left_o == xl, mute_i ? "R7" : "R2", "left_o", 32'(left_o), 32'(xl));
      check(right_o == xr, mute_i ? "R7" : "R2", "right_o", 32'(right_o), 32'(xr));
      if (valid_o) begin cap_l.push_back(left_o); cap_r.push_back(right_o); end
    end
  end

  // stimulus helpers
  task automatic bitslot(input bit lr, input bit d);
    bit_clk_i = 0; frame_clk_i = lr; ser_data_i = d;
    repeat (HB) @(negedge clk_i);
    bit_clk_i = 1;
    repeat (HB) @(negedge clk_i);
  endtask

  task automatic half(input bit lr, input logic [31:0] w, input int n, input int lead);
    for (int i = 0; i < lead; i++) bitslot(lr, 0);
    for (int i = 0; i < n; i++) bitslot(lr, (i < 32) ? w[31-i] : 1'b0);
  endtask

  function automatic bit lr_left();
    return fmt_i ? 1'b0 : 1'b1;
  endfunction

  task automatic frame(input logic [31:0] l, input logic [31:0] r, input int n);
    half(lr_left(), l, n, int'(fmt_i));
    half(!lr_left(), r, n, int'(fmt_i));
  endtask

  task automatic preamble();
    bitslot(!lr_left(), 0);
    bitslot(!lr_left(), 0);
  endtask

  task automatic close_frame();
    bitslot(lr_left(), 0);
  endtask

  task automatic stop_clock();
    repeat (TMO + 36) @(negedge clk_i);
  endtask

  function automatic logic [23:0] exp24(input logic [31:0] w, input int n);
    logic [23:0] v;
    v = w[31:8];
    if (n < 24) v = v & ~(24'hFFFFFF >> n);
    return v;
  endfunction

  task automatic expect_pair(input logic [23:0] l, input logic [23:0] r, input string tag);
    exp_l.push_back(l); exp_r.push_back(r); exp_tag.push_back(tag);
  endtask

  task automatic do_reset();
    chk_en = 0;
    @(negedge clk_i);
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    check(valid_o == 0, "R1", "valid_o in reset", 32'(valid_o), 0);
    check(left_o == 0 && right_o == 0, "R1", "data in reset", 32'(left_o | right_o), 0);
    check(auto_mute_o == 1, "R1", "auto_mute_o in reset", 32'(auto_mute_o), 1);
    rst_ni = 1;
    chk_en = 1;
  endtask

  bit done = 0;

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] wa, wb, wc, wd;
    do_reset();
    // R2 left-justified, full 32-slot halves
    wa = 32'hA5C3_9E12; wb = 32'h1234_5678; wc = 32'hFEDC_BA98; wd = 32'h0F0F_33CC;
    preamble();
    frame(wa, wb, 32); frame(wc, wd, 32); frame(wb, wa, 32);
    close_frame();
    expect_pair(exp24(wa, 32), exp24(wb, 32), "R2");
    expect_pair(exp24(wc, 32), exp24(wd, 32), "R2");
    expect_pair(exp24(wb, 32), exp24(wa, 32), "R2");
    stop_clock();
    check(auto_mute_o == 1, "R8", "auto mute after idle bit clock", 32'(auto_mute_o), 1);
    // R5 short halves, R4 long halves
    preamble();
    frame(32'hFFFF_FFFF, 32'hC3C3_C3C3, 20);
    frame(32'h8765_43FF, 32'h5A5A_5AFF, 28);
    close_frame();
    expect_pair(24'h0, 24'h0, "R9");
    expect_pair(exp24(32'hFFFF_FFFF, 20), exp24(32'hC3C3_C3C3, 20), "R5");
    expect_pair(exp24(32'h8765_43FF, 28), exp24(32'h5A5A_5AFF, 28), "R4");
    stop_clock();
    // R7 mute pin held across the strobe
    preamble();
    frame(wa, wc, 32);
    mute_i = 1;
    close_frame();
    repeat (8) @(negedge clk_i);
    check(left_o == 0 && right_o == 0, "R7", "muted outputs", 32'(left_o | right_o), 0);
    mute_i = 0;
    @(negedge clk_i);
    check(left_o == exp24(wa, 32), "R7", "data after unmute", 32'(left_o), 32'(exp24(wa, 32)));
    expect_pair(24'h0, 24'h0, "R9");
    expect_pair(24'h0, 24'h0, "R7");
    stop_clock();
    // R9 clock lost mid-frame: pair completing on arming change stays zero
    preamble();
    half(lr_left(), wd, 32, 0);
    stop_clock();
    half(!lr_left(), wc, 32, 0);
    frame(wb, wd, 32);
    close_frame();
    expect_pair(24'h0, 24'h0, "R9");
    expect_pair(24'h0, 24'h0, "R9");
    expect_pair(exp24(wb, 32), exp24(wd, 32), "R9");
    check(auto_mute_o == 0, "R9", "released after full frame", 32'(auto_mute_o), 0);
    stop_clock();
    // R3 I2S framing
    @(negedge clk_i);
    fmt_i = 1;
    do_reset();
    preamble();
    frame(wc, wa, 32); frame(wd, wb, 32); frame(32'h9ABC_DEF0, 32'h1357_9BDF, 24);
    close_frame();
    expect_pair(exp24(wc, 32), exp24(wa, 32), "R3");
    expect_pair(exp24(wd, 32), exp24(wb, 32), "R3");
    expect_pair(exp24(32'h9ABC_DEF0, 24), exp24(32'h1357_9BDF, 24), "R3");
    repeat (10) @(negedge clk_i);
    chk_en = 0;
    check(cap_l.size() == exp_l.size(), "R6", "pair count", 32'(cap_l.size()), 32'(exp_l.size()));
    for (int i = 0; i < exp_l.size() && i < cap_l.size(); i++) begin
      check(cap_l[i] == exp_l[i], exp_tag[i], $sformatf("left pair %0d", i), 32'(cap_l[i]), 32'(exp_l[i]));
      check(cap_r[i] == exp_r[i], exp_tag[i], $sformatf("right pair %0d", i), 32'(cap_r[i]), 32'(exp_r[i]));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule